// File: doc/BRIEF.md
# CAN identifier acceptance filter

This block decides whether a received CAN frame is kept. The frame decoder supplies the identifier fields: an 11-bit base identifier, an 18-bit extension, the extended-format flag and the remote-request flag. Alongside these it gives a one-cycle strobe. The block compares the identifier against a set of programmable filter banks. One clock later it reports whether the frame was accepted. For an accepted frame it also reports the number of the filter entry that matched and the receive FIFO that should store the frame. Frames that match nothing are simply reported as rejected, without any processor involvement.

Each bank holds two 32-bit words. Each bank also has four configuration bits: its scale, its mode, its enable and its FIFO assignment. The scale selects one 32-bit filter or two 16-bit filters. The mode selects identifier/mask matching or exact-list matching, so a bank yields one, two or four filter entries. Software programs the banks through a single-cycle write port. A global initialisation flag locks the banks against change while it is clear. While it is set, no frame is accepted.

Top module: `can_filt_top`

## Requirements
- R1: After reset the initialisation flag is set and every bank word and configuration bit is zero. `res_valid` and `res_accept` are low.
- R2: Scale bit 1 with mode bit 0 selects the 32-bit mask mode. The frame word is {sid[10:0], eid[17:0], ide, rtr, 1'b0}, with sid in bits 31:21 and bit 0 zero. Word 1 is the identifier and word 2 the mask. Each bit whose mask bit is 1 must equal the identifier bit; every other bit is ignored. This is one entry.
- R3: Scale bit 1 with mode bit 1 selects the 32-bit list mode. Word 1 and word 2 are each an exact 32-bit identifier in the R2 layout, giving two entries in that order.
- R4: Scale bit 0 with mode bit 0 selects the 16-bit mask mode. The 16-bit frame word is {sid[10:0], ide, rtr, eid[17:15]}. Each bank word gives one entry, with the identifier in bits 15:0 and the mask in bits 31:16, word 1 before word 2.
- R5: Scale bit 0 with mode bit 1 selects the 16-bit list mode. The bank holds four exact 16-bit identifiers, ordered word 1 bits 15:0, word 1 bits 31:16, word 2 bits 15:0, word 2 bits 31:16.
- R6: Filter numbers count entries through the banks in ascending order, all banks included whether enabled or not, at 1, 2, 2 or 4 entries per bank. When several entries match, the lowest bank wins, and within a bank the lowest entry wins.
- R7: A bank whose enable bit is 0 never matches.
- R8: `res_fifo` equals the FIFO-assignment bit of the bank that won.
- R9: A frame strobe in one cycle produces exactly one `res_valid` pulse in the next cycle, with accept, index and FIFO valid in that same cycle.
- R10: A frame matching no enabled entry gives `res_accept`=0, `res_index`=0 and `res_fifo`=0.
- R11: While the initialisation flag is 1, no frame is accepted. While it is 0, writes to bank words and configuration registers are ignored. The flag itself is always writable.
- R12: The write address map, with N banks, places bank b word 1 at 2b and word 2 at 2b+1. Scale bits are at 2N, mode bits at 2N+1, enable bits at 2N+2, FIFO bits at 2N+3 (bit b for bank b), and the initialisation flag at 2N+4, bit 0. Other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: identifier fields are valid |
| frm_sid | input | 11 | Base identifier |
| frm_eid | input | 18 | Identifier extension |
| frm_ide | input | 1 | Extended-format flag |
| frm_rtr | input | 1 | Remote-request flag |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | $clog2(2*NUM_BANKS+5) | Register write address |
| cfg_wdata | input | 32 | Register write data |
| res_valid | output | 1 | Result pulse, one cycle after the strobe |
| res_accept | output | 1 | Frame passed a filter |
| res_index | output | $clog2(4*NUM_BANKS) | Number of the winning filter entry |
| res_fifo | output | 1 | Receive FIFO selected for the frame |

## Verification
The assertions assume that the frame strobe is a plain one-cycle signal whose fields are stable while it is high. They also assume that configuration writes and frame strobes may coincide without any ordering between them. The stimulus never overlaps a write and a frame, and it leaves an idle cycle between frames, so every expected result can be tied to the register state at its strobe. The scoreboard model follows the register write rules, including the lock, and derives each expected index from the entry-count rule.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

    localparam int WORD_W       = 32;
    localparam int HALF_W       = 16;
    localparam int ENT_MAX      = 4;
    localparam int CFG_REGS     = 5;
    localparam int OFS_SCALE    = 0;
    localparam int OFS_MODE     = 1;
    localparam int OFS_EN       = 2;
    localparam int OFS_FIFO     = 3;
    localparam int OFS_INIT     = 4;

    typedef struct packed {
        logic [10:0] sid;
        logic [17:0] eid;
        logic        ide;
        logic        rtr;
    } frame_id_t;

    typedef struct packed {
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w2;
    } bank_words_t;

    typedef struct packed {
        logic wide;
        logic list;
        logic en;
        logic fifo;
    } bank_cfg_t;

    function automatic logic [WORD_W-1:0] pack_word32(frame_id_t f);
        return {f.sid, f.eid, f.ide, f.rtr, 1'b0};
    endfunction

    function automatic logic [HALF_W-1:0] pack_word16(frame_id_t f);
        return {f.sid, f.ide, f.rtr, f.eid[17:15]};
    endfunction

    function automatic logic [2:0] entries_of(logic wide, logic list);
        case ({wide, list})
            2'b10:   return 3'd1;
            2'b11:   return 3'd2;
            2'b00:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] first_hit(logic [ENT_MAX-1:0] h);
        if (h[0])      return 2'd0;
        else if (h[1]) return 2'd1;
        else if (h[2]) return 2'd2;
        else           return 2'd3;
    endfunction

endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
    import can_filt_pkg::*;
#(
    parameter int NUM_BANKS = 14,
    parameter int ADDR_W    = 6
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [WORD_W-1:0]                 wdata,
    output bank_words_t [NUM_BANKS-1:0]       words_o,
    output bank_cfg_t   [NUM_BANKS-1:0]       cfg_o,
    output logic                              init_o
);

    localparam logic [ADDR_W-1:0] A_WORD_END = ADDR_W'(2 * NUM_BANKS);
    localparam logic [ADDR_W-1:0] A_SCALE    = ADDR_W'(2 * NUM_BANKS + OFS_SCALE);
    localparam logic [ADDR_W-1:0] A_MODE     = ADDR_W'(2 * NUM_BANKS + OFS_MODE);
    localparam logic [ADDR_W-1:0] A_EN       = ADDR_W'(2 * NUM_BANKS + OFS_EN);
    localparam logic [ADDR_W-1:0] A_FIFO     = ADDR_W'(2 * NUM_BANKS + OFS_FIFO);
    localparam logic [ADDR_W-1:0] A_INIT     = ADDR_W'(2 * NUM_BANKS + OFS_INIT);

    bank_words_t [NUM_BANKS-1:0] words_q;
    logic [NUM_BANKS-1:0]        scale_q, mode_q, en_q, fifo_q;
    logic                        init_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
            scale_q <= '0;
            mode_q  <= '0;
            en_q    <= '0;
            fifo_q  <= '0;
            init_q  <= 1'b1;
        end else if (we) begin
            if (addr == A_INIT) begin
                init_q <= wdata[0];
            end else if (init_q) begin
                if (addr < A_WORD_END) begin
                    if (addr[0]) words_q[addr[ADDR_W-1:1]].w2 <= wdata;
                    else         words_q[addr[ADDR_W-1:1]].w1 <= wdata;
                end else begin
                    case (addr)
                        A_SCALE: scale_q <= wdata[NUM_BANKS-1:0];
                        A_MODE:  mode_q  <= wdata[NUM_BANKS-1:0];
                        A_EN:    en_q    <= wdata[NUM_BANKS-1:0];
                        A_FIFO:  fifo_q  <= wdata[NUM_BANKS-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cfg
        assign cfg_o[b] = '{wide: scale_q[b], list: mode_q[b], en: en_q[b], fifo: fifo_q[b]};
    end

    assign words_o = words_q;
    assign init_o  = init_q;

endmodule

// File: rtl/can_filt_bank.sv
module can_filt_bank
    import can_filt_pkg::*;
(
    input  bank_words_t         words,
    input  logic                wide,
    input  logic                list,
    input  frame_id_t           fid,
    output logic [ENT_MAX-1:0]  hit_o
);

    logic [WORD_W-1:0] w32;
    logic [HALF_W-1:0] w16;

    assign w32 = pack_word32(fid);
    assign w16 = pack_word16(fid);

    always_comb begin
        hit_o = '0;
        case ({wide, list})
            2'b10: begin
                hit_o[0] = ((w32 ^ words.w1) & words.w2) == '0;
            end
            2'b11: begin
                hit_o[0] = (w32 == words.w1);
                hit_o[1] = (w32 == words.w2);
            end
            2'b00: begin
                hit_o[0] = ((w16 ^ words.w1[15:0]) & words.w1[31:16]) == '0;
                hit_o[1] = ((w16 ^ words.w2[15:0]) & words.w2[31:16]) == '0;
            end
            default: begin
                hit_o[0] = (w16 == words.w1[15:0]);
                hit_o[1] = (w16 == words.w1[31:16]);
                hit_o[2] = (w16 == words.w2[15:0]);
                hit_o[3] = (w16 == words.w2[31:16]);
            end
        endcase
    end

endmodule

// File: rtl/can_filt_pick.sv
module can_filt_pick
    import can_filt_pkg::*;
#(
    parameter int NUM_BANKS = 14,
    parameter int IDX_W     = 6
) (
    input  logic [NUM_BANKS-1:0][ENT_MAX-1:0] hits,
    input  bank_cfg_t [NUM_BANKS-1:0]         cfg,
    output logic                              found_o,
    output logic [IDX_W-1:0]                  idx_o,
    output logic                              fifo_o
);

    always_comb begin
        logic [IDX_W-1:0]   base;
        logic [ENT_MAX-1:0] live;
        found_o = 1'b0;
        idx_o   = '0;
        fifo_o  = 1'b0;
        base    = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            live = hits[b] & {ENT_MAX{cfg[b].en}};
            if (!found_o && (live != '0)) begin
                found_o = 1'b1;
                fifo_o  = cfg[b].fifo;
                idx_o   = base + IDX_W'(first_hit(live));
            end
            base = base + IDX_W'(entries_of(cfg[b].wide, cfg[b].list));
        end
    end

endmodule

// File: rtl/can_filt_top.sv
module can_filt_top
    import can_filt_pkg::*;
#(
    parameter int NUM_BANKS = 14
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               frm_valid,
    input  logic [10:0]                        frm_sid,
    input  logic [17:0]                        frm_eid,
    input  logic                               frm_ide,
    input  logic                               frm_rtr,
    input  logic                               cfg_we,
    input  logic [$clog2(2*NUM_BANKS+5)-1:0]   cfg_addr,
    input  logic [31:0]                        cfg_wdata,
    output logic                               res_valid,
    output logic                               res_accept,
    output logic [$clog2(4*NUM_BANKS)-1:0]     res_index,
    output logic                               res_fifo
);

    localparam int ADDR_W = $clog2(2 * NUM_BANKS + CFG_REGS);
    localparam int IDX_W  = $clog2(ENT_MAX * NUM_BANKS);

    frame_id_t                        fid;
    bank_words_t [NUM_BANKS-1:0]      regs_w;
    bank_cfg_t   [NUM_BANKS-1:0]      cfg_w;
    logic                             init_w;
    logic [NUM_BANKS-1:0][ENT_MAX-1:0] hits_w;
    logic                             found_w, fifo_w;
    logic [IDX_W-1:0]                 idx_w;
    logic                             take_w;

    assign fid = '{sid: frm_sid, eid: frm_eid, ide: frm_ide, rtr: frm_rtr};

    can_filt_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .words_o(regs_w), .cfg_o(cfg_w), .init_o(init_w)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        can_filt_bank bank_i (
            .words(regs_w[b]), .wide(cfg_w[b].wide), .list(cfg_w[b].list),
            .fid(fid), .hit_o(hits_w[b])
        );
    end

    can_filt_pick #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) pick_i (
        .hits(hits_w), .cfg(cfg_w), .found_o(found_w), .idx_o(idx_w), .fifo_o(fifo_w)
    );

    assign take_w = frm_valid && found_w && !init_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_index  <= '0;
            res_fifo   <= 1'b0;
        end else begin
            res_valid  <= frm_valid;
            res_accept <= take_w;
            res_index  <= take_w ? idx_w : '0;
            res_fifo   <= take_w ? fifo_w : 1'b0;
        end
    end

endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk #(
    parameter int NUM_BANKS = 14,
    parameter int IDX_W     = 6
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      frm_valid,
    input logic                      cfg_we,
    input logic                      res_valid,
    input logic                      res_accept,
    input logic [IDX_W-1:0]          res_index,
    input logic                      res_fifo,
    input logic                      init_q,
    input logic [NUM_BANKS*64-1:0]   regs_flat
);

    // R9: each strobe yields a result in the next cycle
    a_r9_result_follows: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> res_valid);

    // R9: no result without a strobe in the previous cycle
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !res_valid);

    // R9: accept only appears with the result pulse
    a_r9_accept_in_pulse: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_accept);

    // R10: rejected results carry zero index and FIFO
    a_r10_reject_zeroed: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_accept) |-> (res_index == '0 && !res_fifo));

    // R11: nothing accepted while initialising
    a_r11_init_blocks: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && init_q) |=> !res_accept);

    // R11: bank words frozen while the flag is clear
    a_r11_words_locked: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !init_q) |=> $stable(regs_flat));

    // R6: index stays inside the entry range
    a_r6_index_range: assert property (@(posedge clk) disable iff (rst)
        res_accept |-> (int'(res_index) < 4 * NUM_BANKS));

endmodule

bind can_filt_top can_filt_chk #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .cfg_we(cfg_we),
    .res_valid(res_valid), .res_accept(res_accept), .res_index(res_index),
    .res_fifo(res_fifo), .init_q(init_w), .regs_flat(regs_w)
);

// File: tb/can_filt_top_tb_top.sv
module can_filt_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 14;
    localparam int ADDR_W     = $clog2(2 * NB + 5);
    localparam int IDX_W      = $clog2(4 * NB);
    localparam int A_SCALE    = 2 * NB;
    localparam int A_MODE     = 2 * NB + 1;
    localparam int A_EN       = 2 * NB + 2;
    localparam int A_FIFO     = 2 * NB + 3;
    localparam int A_INIT     = 2 * NB + 4;

    typedef struct packed {
        logic             acc;
        logic [IDX_W-1:0] idx;
        logic             fifo;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frm_valid = 1'b0;
    logic [10:0]       frm_sid = '0;
    logic [17:0]       frm_eid = '0;
    logic              frm_ide = 1'b0;
    logic              frm_rtr = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              res_valid, res_accept, res_fifo;
    logic [IDX_W-1:0]  res_index;

    can_filt_top #(.NUM_BANKS(NB)) dut_i (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_sid(frm_sid),
        .frm_eid(frm_eid), .frm_ide(frm_ide), .frm_rtr(frm_rtr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .res_valid(res_valid), .res_accept(res_accept),
        .res_index(res_index), .res_fifo(res_fifo)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    logic [31:0]   m_w1 [NB];
    logic [31:0]   m_w2 [NB];
    logic [NB-1:0] m_scale, m_mode, m_en, m_fifo;
    logic          m_init;

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %s expected %s", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] w32(logic [10:0] s, logic [17:0] e, logic i, logic r);
        return {s, e, i, r, 1'b0};
    endfunction

    function automatic logic [15:0] w16(logic [10:0] s, logic [2:0] e, logic i, logic r);
        return {s, i, r, e};
    endfunction

    function automatic exp_t model(logic [10:0] s, logic [17:0] e, logic i, logic r);
        logic [31:0] f32;
        logic [15:0] f16;
        logic [3:0]  h;
        int          base;
        int          n;
        exp_t        x;
        f32  = w32(s, e, i, r);
        f16  = w16(s, e[17:15], i, r);
        base = 0;
        x    = '0;
        if (m_init) return x;
        for (int b = 0; b < NB; b++) begin
            h = '0;
            if (m_scale[b] && !m_mode[b]) begin
                n = 1; h[0] = ((f32 ^ m_w1[b]) & m_w2[b]) == 0;
            end else if (m_scale[b]) begin
                n = 2; h[0] = f32 == m_w1[b]; h[1] = f32 == m_w2[b];
            end else if (!m_mode[b]) begin
                n = 2;
                h[0] = ((f16 ^ m_w1[b][15:0]) & m_w1[b][31:16]) == 0;
                h[1] = ((f16 ^ m_w2[b][15:0]) & m_w2[b][31:16]) == 0;
            end else begin
                n = 4;
                h = {f16 == m_w2[b][31:16], f16 == m_w2[b][15:0],
                     f16 == m_w1[b][31:16], f16 == m_w1[b][15:0]};
            end
            if (!m_en[b]) h = '0;
            if (!x.acc && h != 0) begin
                x.acc  = 1'b1;
                x.fifo = m_fifo[b];
                for (int k = 3; k >= 0; k--) if (h[k]) x.idx = IDX_W'(base + k);
            end
            base += n;
        end
        return x;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_wdata = d;
        if (a == A_INIT) m_init = d[0];
        else if (m_init) begin
            if (a < 2 * NB) begin
                if (a % 2 == 0) m_w1[a / 2] = d; else m_w2[a / 2] = d;
            end
            else if (a == A_SCALE) m_scale = d[NB-1:0];
            else if (a == A_MODE)  m_mode  = d[NB-1:0];
            else if (a == A_EN)    m_en    = d[NB-1:0];
            else if (a == A_FIFO)  m_fifo  = d[NB-1:0];
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [10:0] s, input logic [17:0] e, input logic i,
                        input logic r, input string tag);
        @(negedge clk);
        frm_sid = s; frm_eid = e; frm_ide = i; frm_rtr = r; frm_valid = 1'b1;
        exp_q.push_back(model(s, e, i, r));
        tag_q.push_back(tag);
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    // monitor: compare each result pulse with the oldest expected item
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected result", "no result");
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({res_accept, res_index, res_fifo} == e, t,
                      $sformatf("acc=%0b idx=%0d fifo=%0b", res_accept, res_index, res_fifo),
                      $sformatf("acc=%0b idx=%0d fifo=%0b", e.acc, e.idx, e.fifo));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "watchdog", "timeout", "completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin m_w1[b] = '0; m_w2[b] = '0; end
        m_scale = '0; m_mode = '0; m_en = '0; m_fifo = '0; m_init = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!res_valid && !res_accept, "R1",
              $sformatf("valid=%0b acc=%0b", res_valid, res_accept), "valid=0 acc=0");
        send(11'h123, 18'h0, 1'b0, 1'b0, "R1 reset banks reject");

        // bank 0: 32-bit mask on sid only; bank 1: 32-bit list
        wr(0, w32(11'h123, 18'h0, 1'b0, 1'b0));
        wr(1, 32'hFFE0_0000);
        wr(2, w32(11'h200, 18'h2ABCD, 1'b1, 1'b0));
        wr(3, w32(11'h055, 18'h0, 1'b0, 1'b1));
        // bank 2: 16-bit mask pairs {mask, id}
        wr(4, {16'hFFE0, w16(11'h300, 3'd0, 1'b0, 1'b0)});
        wr(5, {16'hFFFF, w16(11'h7FF, 3'd0, 1'b0, 1'b1)});
        // bank 3: 16-bit list of four
        wr(6, {w16(11'h011, 3'd0, 1'b0, 1'b0), w16(11'h010, 3'd0, 1'b0, 1'b0)});
        wr(7, {w16(11'h013, 3'd0, 1'b0, 1'b0), w16(11'h012, 3'd0, 1'b0, 1'b0)});
        // bank 4: match-all mask, left disabled; bank 5: any extended frame
        wr(8, 32'h0); wr(9, 32'h0);
        wr(10, 32'h4); wr(11, 32'h4);
        wr(A_SCALE, 32'h33);
        wr(A_MODE, 32'h0A);
        wr(A_EN, 32'h2F);
        wr(A_FIFO, 32'h24);
        send(11'h123, 18'h0, 1'b0, 1'b0, "R11 init set blocks accept");
        wr(A_INIT, 32'h0);

        send(11'h123, 18'h15, 1'b0, 1'b1, "R2 mask ignores low bits");
        send(11'h124, 18'h0, 1'b0, 1'b0, "R10 no match");
        send(11'h124, 18'h0, 1'b0, 1'b0, "R7 disabled match-all bank");
        send(11'h200, 18'h2ABCD, 1'b1, 1'b0, "R6 lower bank wins over bank 5");
        send(11'h055, 18'h0, 1'b0, 1'b1, "R3 second list entry");
        send(11'h055, 18'h0, 1'b0, 1'b0, "R3 rtr mismatch rejects");
        send(11'h300, 18'h38000, 1'b0, 1'b1, "R4 16-bit mask entry 0");
        send(11'h7FF, 18'h07FFF, 1'b0, 1'b1, "R4 16-bit exact entry 1");
        send(11'h7FF, 18'h0, 1'b0, 1'b0, "R4 rtr mismatch rejects");
        send(11'h010, 18'h0, 1'b0, 1'b0, "R5 list slot 0");
        send(11'h011, 18'h0, 1'b0, 1'b0, "R5 list slot 1");
        send(11'h012, 18'h0, 1'b0, 1'b0, "R5 list slot 2");
        send(11'h013, 18'h0, 1'b0, 1'b0, "R5 list slot 3");
        send(11'h400, 18'h12345, 1'b1, 1'b1, "R8 R6 bank 5 fifo and index");

        // locked writes are ignored
        wr(0, w32(11'h124, 18'h0, 1'b0, 1'b0));
        wr(A_EN, 32'h0);
        send(11'h123, 18'h0, 1'b0, 1'b0, "R11 locked write ignored");
        send(11'h124, 18'h0, 1'b0, 1'b0, "R11 locked id unchanged");

        wr(A_INIT, 32'h1);
        send(11'h123, 18'h0, 1'b0, 1'b0, "R11 re-entered init blocks");
        wr(0, w32(11'h124, 18'h0, 1'b0, 1'b0));
        wr(A_INIT, 32'h0);
        send(11'h124, 18'h0, 1'b0, 1'b0, "R12 word 1 of bank 0 rewritten");
        send(11'h123, 18'h0, 1'b0, 1'b0, "R12 old id gone");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9",
              $sformatf("%0d pending", exp_q.size()), "0 pending");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule